// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block watches for a stalled or runaway program. A counter advances on a selectable watchdog tick. The tick is either an externally generated RC tick, sampled once per system clock cycle, or the instruction clock, which is derived here as one tick every fourth system clock. The tick stream first passes a fixed binary divider of `FIX_BITS` stages, 256 by default. It then passes a prescaler whose ratio is 1:2^s, where s is held in the low three bits of an 8-bit control register. When the full span has elapsed without a clear, the block emits a one-cycle overflow pulse and restarts from zero. The pulse appears on one output when the device runs and on another when it sleeps, so the surrounding logic can choose between a full reset and a warm reset.

Software keeps the watchdog quiet with clear commands. In single-clear mode one command is enough. In dual-clear mode two distinct commands must both be seen, in any order, before the count restarts. Entering the sleep state and the synchronous reset also restart the count. A configuration input disables the whole function. The upper five bits of the control register are free storage for software.

Top module: `wdog_timer`

## Requirements
- R1: After `rst` the control register reads 8'h07, both overflow outputs are low, and the count, the tick divider and any pending half-clear are zero.
- R2: A write with `reg_wr` high stores all eight bits of `reg_wdata`, and `reg_rdata` shows them from the next cycle. Bits 7..3 are user storage and do not change any timeout.
- R3: With select value s in register bits 2..0, an overflow occurs after 2^(FIX_BITS+s) watchdog ticks counted from the last clear.
- R4: With `cfg_src_rc` high, each cycle with `rc_tick` high is one tick. With `cfg_src_rc` low, a tick occurs every fourth cycle, and the phase of that divide-by-4 restarts at every clear. An overflow is therefore seen 2^(FIX_BITS+s) cycles (RC, `rc_tick` held high) or 4·2^(FIX_BITS+s) cycles (instruction clock) after the clear edge.
- R5: Each overflow is a pulse of exactly one cycle, and counting wraps to zero, so the next pulse follows one full timeout later.
- R6: The overflow drives `ovf_chip_rst` when `halt_mode` is low and `ovf_warm_rst` when it is high, never both together.
- R7: With the instruction clock selected and `halt_mode` high, the count and the tick divider hold still.
- R8: With `cfg_dual_clear` low, `clr_single` clears the count, and `clr_one` and `clr_two` are ignored.
- R9: With `cfg_dual_clear` high, the count clears only once both `clr_one` and `clr_two` have been seen, in either order or in the same cycle. `clr_single` is ignored.
- R10: A pending half-clear is discarded whenever the count is cleared by any means, so a later single command of the other kind does not clear.
- R11: `halt_enter` and `rst` each clear the count and the tick divider, in either clear mode.
- R12: With `cfg_enable` low, no overflow is produced, the count holds at zero and clear commands have no effect.
- R13: A clear in the same cycle as a terminal tick wins: no pulse is produced and a full timeout restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| cfg_enable | input | 1 | Watchdog enabled |
| cfg_src_rc | input | 1 | 1: RC tick source, 0: instruction clock (clk/4) |
| cfg_dual_clear | input | 1 | 1: two distinct clear commands needed |
| rc_tick | input | 1 | Tick from the RC oscillator, synchronous to clk |
| halt_mode | input | 1 | Device is in the sleep state |
| halt_enter | input | 1 | Pulse on entry to the sleep state |
| clr_single | input | 1 | Single clear command |
| clr_one | input | 1 | First command of a clear pair |
| clr_two | input | 1 | Second command of a clear pair |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| ovf_chip_rst | output | 1 | Overflow pulse while running (full reset request) |
| ovf_warm_rst | output | 1 | Overflow pulse while sleeping (warm reset request) |

## Verification
The assertions check on every cycle the properties that hold locally in time. The overflow pulse lasts a single cycle and only one of its two forms is active. A clear blocks a pulse in the following cycle, a disabled watchdog stays quiet, a clear leaves the count at zero, and the count stays frozen while the instruction clock is asleep. In dual-clear mode they also check that no clear fires without a pair command or a sleep entry. The exact timeout length for every select value and both sources, the restart of the tick phase, the order independence of the clear pair and the discarding of a half-clear can only be shown by the bench. It measures the cycle distance from a clear edge to each pulse and compares it with 2^(FIX_BITS+s) or four times that.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CTRL_W       = 8;
    localparam int SEL_W        = 3;
    localparam int PRESC_STAGES = (1 << SEL_W) - 1;
    localparam int NSEL         = PRESC_STAGES + 1;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h07;

    typedef struct packed {
        logic [CTRL_W-SEL_W-1:0] user;
        logic [SEL_W-1:0]        sel;
    } wdt_ctrl_t;

    typedef enum logic [1:0] {
        OVF_NONE = 2'b00,
        OVF_CHIP = 2'b01,
        OVF_WARM = 2'b10
    } ovf_kind_e;

    function automatic ovf_kind_e ovf_kind(input logic fire, input logic sleeping);
        if (!fire)
            return OVF_NONE;
        return sleeping ? OVF_WARM : OVF_CHIP;
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output wdt_ctrl_t         ctrl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= wdt_ctrl_t'(CTRL_RST);
        else if (wr)
            ctrl <= wdt_ctrl_t'(wdata);
    end

endmodule

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
    parameter int IDIV_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic src_rc,
    input  logic rc_tick,
    input  logic halt_mode,
    input  logic restart,
    output logic tick
);

    logic [IDIV_BITS-1:0] phase;
    logic                 instr_tick;

    always_ff @(posedge clk) begin
        if (rst || restart || !en)
            phase <= '0;
        else if (!halt_mode)
            phase <= phase + IDIV_BITS'(1);
    end

    assign instr_tick = (&phase) && !halt_mode;
    assign tick       = en && (src_rc ? rc_tick : instr_tick);

    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (halt_mode && !restart && en) |=> $stable(phase)) else $error("phase moved in halt"); // R7

endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dual,
    input  logic clr_single,
    input  logic clr_one,
    input  logic clr_two,
    input  logic halt_enter,
    output logic clr_fire
);

    logic seen_one, seen_two;
    logic sw_clr;

    always_comb begin
        if (dual)
            sw_clr = (seen_one || clr_one) && (seen_two || clr_two);
        else
            sw_clr = clr_single;
    end

    assign clr_fire = en && (sw_clr || halt_enter);

    always_ff @(posedge clk) begin
        if (rst || clr_fire || !en || !dual) begin
            seen_one <= 1'b0;
            seen_two <= 1'b0;
        end else begin
            if (clr_one) seen_one <= 1'b1;
            if (clr_two) seen_two <= 1'b1;
        end
    end

    AST_DUAL_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        (dual && !halt_enter && !clr_one && !clr_two) |-> !clr_fire) else $error("lone clear in dual mode"); // R9

    AST_PENDING_DROPPED: assert property (@(posedge clk) disable iff (rst)
        clr_fire |=> !(seen_one || seen_two)) else $error("half-clear survived"); // R10

endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int FIX_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             halt_mode,
    output logic [FIX_BITS+PRESC_STAGES-1:0] cnt,
    output logic             ovf_chip,
    output logic             ovf_warm
);

    localparam int CW = FIX_BITS + PRESC_STAGES;

    logic [CW-1:0] mask [NSEL];
    logic [CW-1:0] cur_mask;
    logic          term, wrap;
    ovf_kind_e     kind;

    for (genvar s = 0; s < NSEL; s++) begin : g_mask
        assign mask[s] = ~({CW{1'b1}} << (FIX_BITS + s));
    end

    assign cur_mask = mask[sel];
    assign term     = (cnt & cur_mask) == cur_mask;
    assign wrap     = en && tick && term && !clr;
    assign kind     = ovf_kind(wrap, halt_mode);

    always_ff @(posedge clk) begin
        if (rst || clr || !en)
            cnt <= '0;
        else if (tick)
            cnt <= term ? '0 : cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_chip <= 1'b0;
            ovf_warm <= 1'b0;
        end else begin
            ovf_chip <= (kind == OVF_CHIP);
            ovf_warm <= (kind == OVF_WARM);
        end
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)) else $error("count not zero after clear"); // R11

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_chip, ovf_warm})) else $error("both overflow kinds"); // R6

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int FIX_BITS  = 8,
    parameter int IDIV_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_src_rc,
    input  logic              cfg_dual_clear,
    input  logic              rc_tick,
    input  logic              halt_mode,
    input  logic              halt_enter,
    input  logic              clr_single,
    input  logic              clr_one,
    input  logic              clr_two,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    output logic              ovf_chip_rst,
    output logic              ovf_warm_rst
);

    localparam int CW = FIX_BITS + PRESC_STAGES;

    wdt_ctrl_t     ctrl;
    logic          clr_fire;
    logic          tick;
    logic [CW-1:0] cnt_q;

    wdt_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    wdt_clear_ctl u_clr (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_enable),
        .dual       (cfg_dual_clear),
        .clr_single (clr_single),
        .clr_one    (clr_one),
        .clr_two    (clr_two),
        .halt_enter (halt_enter),
        .clr_fire   (clr_fire)
    );

    wdt_tick_src #(.IDIV_BITS(IDIV_BITS)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_enable),
        .src_rc    (cfg_src_rc),
        .rc_tick   (rc_tick),
        .halt_mode (halt_mode),
        .restart   (clr_fire),
        .tick      (tick)
    );

    wdt_count #(.FIX_BITS(FIX_BITS)) u_count (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_enable),
        .tick      (tick),
        .clr       (clr_fire),
        .sel       (ctrl.sel),
        .halt_mode (halt_mode),
        .cnt       (cnt_q),
        .ovf_chip  (ovf_chip_rst),
        .ovf_warm  (ovf_warm_rst)
    );

    assign reg_rdata = ctrl;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ovf_chip_rst || ovf_warm_rst) |=> !(ovf_chip_rst || ovf_warm_rst)) else $error("wide pulse"); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_fire |=> !(ovf_chip_rst || ovf_warm_rst)) else $error("pulse after clear"); // R13

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !(ovf_chip_rst || ovf_warm_rst)) else $error("pulse while disabled"); // R12

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halt_mode && !cfg_src_rc && cfg_enable && !clr_fire) |=> $stable(cnt_q)) else $error("count moved in halt"); // R7

endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

    localparam int FB = 2;

    logic       clk = 1'b0;
    logic       rst, cfg_enable, cfg_src_rc, cfg_dual_clear, rc_tick;
    logic       halt_mode, halt_enter, clr_single, clr_one, clr_two, reg_wr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       ovf_chip_rst, ovf_warm_rst;

    int nvec = 0;
    int nbad = 0;
    bit finished = 0;

    always #2ns clk = ~clk; // 250 MHz

    wdog_timer #(.FIX_BITS(FB)) dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_src_rc(cfg_src_rc),
        .cfg_dual_clear(cfg_dual_clear), .rc_tick(rc_tick), .halt_mode(halt_mode),
        .halt_enter(halt_enter), .clr_single(clr_single), .clr_one(clr_one),
        .clr_two(clr_two), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ovf_chip_rst(ovf_chip_rst), .ovf_warm_rst(ovf_warm_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmds(input bit s, input bit o, input bit t, input bit h);
        clr_single = s; clr_one = o; clr_two = t; halt_enter = h;
        @(posedge clk); @(negedge clk);
        clr_single = 0; clr_one = 0; clr_two = 0; halt_enter = 0;
    endtask

    task automatic do_write(input logic [7:0] v);
        reg_wr = 1; reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic run(input int k, input string tag);
        bit seen = 0;
        for (int i = 0; i < k; i++) begin
            @(posedge clk); @(negedge clk);
            if (ovf_chip_rst || ovf_warm_rst) seen = 1;
        end
        check(!seen, tag, int'(seen), 0);
    endtask

    task automatic expect_period(input int exp, input bit warm, input string tag);
        int m = 0;
        bit ch = 0, wm = 0;
        while (m < 2 * exp + 8) begin
            @(posedge clk); m++; @(negedge clk);
            if (ovf_chip_rst || ovf_warm_rst) begin
                ch = ovf_chip_rst; wm = ovf_warm_rst;
                break;
            end
        end
        check(m == exp, tag, m, exp);
        check(ch == !warm && wm == warm, "R6", int'({ch, wm}), int'({!warm, warm}));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int T;
        rst = 1; cfg_enable = 1; cfg_src_rc = 0; cfg_dual_clear = 0; rc_tick = 1;
        halt_mode = 0; halt_enter = 0; clr_single = 0; clr_one = 0; clr_two = 0;
        reg_wr = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check(reg_rdata == 8'h07, "R1", reg_rdata, 8'h07);
        check(!ovf_chip_rst && !ovf_warm_rst, "R1", int'({ovf_chip_rst, ovf_warm_rst}), 0);

        do_write(8'hA5);
        check(reg_rdata == 8'hA5, "R2", reg_rdata, 8'hA5);

        // sweep: both sources, every select, varying user bits
        for (int src = 0; src < 2; src++) begin
            for (int s = 0; s < 8; s++) begin
                logic [7:0] v;
                int exp;
                v = {5'(s * 5 + 3 + src * 11), 3'(s)};
                cfg_src_rc = src[0];
                do_write(v);
                check(reg_rdata == v, "R2", reg_rdata, v);
                cmds(1, 0, 0, 0);
                exp = (1 << (FB + s)) * (src == 1 ? 1 : 4);
                expect_period(exp, 0, src == 1 ? "R4" : "R3");
                @(posedge clk); @(negedge clk);
                check(!(ovf_chip_rst || ovf_warm_rst), "R5", int'(ovf_chip_rst), 0);
                expect_period(exp - 1, 0, "R5");
            end
        end

        // directed cases, instruction clock, select 1
        cfg_src_rc = 0;
        do_write(8'h01);
        T = 4 * (1 << (FB + 1));

        cmds(1, 0, 0, 0); run(10, "R8"); cmds(0, 1, 1, 0);
        expect_period(T - 11, 0, "R8");

        cmds(1, 0, 0, 0); run(T - 1, "R13"); cmds(1, 0, 0, 0);
        check(!(ovf_chip_rst || ovf_warm_rst), "R13", int'(ovf_chip_rst), 0);
        expect_period(T, 0, "R13");

        cmds(1, 0, 0, 0); run(10, "R11"); cmds(0, 0, 0, 1);
        expect_period(T, 0, "R11");

        cmds(1, 0, 0, 0); run(9, "R11");
        rst = 1; @(posedge clk); @(negedge clk); rst = 0;
        check(reg_rdata == 8'h07, "R11", reg_rdata, 8'h07);
        expect_period(4 * (1 << (FB + 7)), 0, "R11");
        do_write(8'h01);

        cfg_dual_clear = 1;
        cmds(0, 1, 1, 0); run(5, "R9"); cmds(0, 0, 1, 0);
        expect_period(T - 6, 0, "R9");
        cmds(0, 1, 1, 0); run(10, "R9"); cmds(0, 1, 0, 0); run(5, "R9");
        cmds(1, 0, 0, 0); run(3, "R9"); cmds(0, 0, 1, 0);
        expect_period(T, 0, "R9");
        cmds(0, 1, 1, 0); run(4, "R9"); cmds(0, 0, 1, 0); run(2, "R9"); cmds(0, 1, 0, 0);
        expect_period(T, 0, "R9");

        cmds(0, 1, 1, 0); run(3, "R10"); cmds(0, 1, 0, 0); cmds(0, 0, 0, 1);
        run(4, "R10"); cmds(0, 0, 1, 0);
        expect_period(T - 5, 0, "R10");
        cfg_dual_clear = 0;

        cmds(1, 0, 0, 0); halt_mode = 1; run(4 * T, "R7");
        halt_mode = 0;
        expect_period(T, 0, "R7");

        cfg_src_rc = 1; halt_mode = 1;
        cmds(1, 0, 0, 0);
        expect_period(1 << (FB + 1), 1, "R6");
        halt_mode = 0; cfg_src_rc = 0;

        cfg_enable = 0; run(2 * T, "R12"); cmds(1, 1, 1, 1); run(2 * T, "R12");
        cfg_enable = 1;
        expect_period(T, 0, "R12");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule